// File: doc/BRIEF.md
# Pipelined 4x4 Inverse Integer Transform with Reconstruction

This block turns one 4x4 block of dequantised transform coefficients into spatial residuals and reconstructed samples. The transform is separable. A row pass runs four one-dimensional butterfly units side by side, one per row. A column pass then runs four more, one per column. The butterfly weights are only plus or minus one and plus or minus one half, so the datapath uses adders, subtractors and arithmetic right shifts and has no multipliers. The second pass finishes in a rounding stage. A reconstruction stage, registered twice, adds the prediction samples and clips each sum to the valid pixel range.

Blocks enter and leave through a valid/ready stream. A block is taken on a clock edge where `in_valid` and `in_ready` are both high. A result leaves on an edge where `out_valid` and `out_ready` are both high. The pipeline advances as one piece. When the output holds a result that has not been taken, every stage freezes and `in_ready` drops. When the consumer is ready, one block can enter and one can leave on the same cycle.

Top module: `itx4_recon`

## Requirements
- R1: `in_ready` is high exactly when `out_valid` is low or `out_ready` is high. While `out_valid` is high and `out_ready` is low, `out_valid`, `out_res` and `out_pix` hold their values on the next cycle.
- R2: Coefficient k (k = 4*row + column) sits in `in_coef[16k+15:16k]` as 16-bit two's complement. Each row of four values x0..x3 is transformed first, then each column of the row results. A 1-D unit forms a=x0+x2, b=x0-x2, c=(x1>>>1)-x3, d=x1+(x3>>>1) and outputs a+d, b+c, b-c, a-d. The halving is an arithmetic shift, so it rounds toward minus infinity.
- R3: Every value v from the column pass leaves as (v+32)>>>6. It is placed on `out_res[15k+14:15k]` as 15-bit two's complement, lane k in the same row-major order as the input.
- R4: `out_pix[8k+7:8k]` equals residual k plus the unsigned prediction `in_pred[8k+7:8k]`, clipped to 0..255.
- R5: With `out_ready` held high and the pipeline empty, `out_valid` goes high on the fourth rising edge, counting the edge that accepts the block as the first.
- R6: With `out_ready` held high, one block is accepted on every cycle. Results leave in the order in which the blocks were accepted.
- R7: Any 16-bit input values, including all lanes at +32767 or at -32768, give exactly the results of R2 and R3 computed without overflow.
- R8: While `rst_n` is low, `out_valid` is low. With `out_ready` high, `in_ready` is then high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input block present |
| in_ready | output | 1 | Block accepted on this edge if valid |
| in_coef | input | 256 | 16 signed coefficients, row-major |
| in_pred | input | 128 | 16 unsigned prediction samples, row-major |
| out_valid | output | 1 | Result block present |
| out_ready | input | 1 | Consumer takes the result on this edge |
| out_res | output | 240 | 16 signed rounded residuals, 15 bits each |
| out_pix | output | 128 | 16 reconstructed clipped samples |

## Verification
A block can be accepted at the input on the same edge as an earlier result is taken at the output, and a stall at the output must also freeze the input. Both situations are provoked by streaming blocks back to back while `out_ready` follows a pseudo-random pattern. Each cycle the bench checks that a stalled output holds its data and that `in_ready` is low. Every result that leaves is compared with a reference model run on the blocks in the order they were accepted. A separate sustained burst with `out_ready` held high confirms that eight blocks are accepted on eight consecutive cycles.

// File: rtl/itx_pkg.sv
package itx_pkg;
  localparam int N_SIDE  = 4;
  localparam int N_LANE  = N_SIDE * N_SIDE;
  localparam int RND_SH  = 6;
  localparam int RND_OFS = 1 << (RND_SH - 1);
  localparam int GROWTH  = 5;
endpackage

// File: rtl/itx_bfly.sv
module itx_bfly #(
  parameter int W = 21
) (
  input  logic signed [W-1:0] x0,
  input  logic signed [W-1:0] x1,
  input  logic signed [W-1:0] x2,
  input  logic signed [W-1:0] x3,
  output logic signed [W-1:0] y0,
  output logic signed [W-1:0] y1,
  output logic signed [W-1:0] y2,
  output logic signed [W-1:0] y3
);
  logic signed [W-1:0] ev_sum, ev_dif, od_lo, od_hi;

  // the weights of one half are arithmetic shifts
  assign ev_sum = x0 + x2;
  assign ev_dif = x0 - x2;
  assign od_lo  = (x1 >>> 1) - x3;
  assign od_hi  = x1 + (x3 >>> 1);

  assign y0 = ev_sum + od_hi;
  assign y1 = ev_dif + od_lo;
  assign y2 = ev_dif - od_lo;
  assign y3 = ev_sum - od_hi;
endmodule

// File: rtl/itx_recon_lane.sv
module itx_recon_lane #(
  parameter int RES_W = 15,
  parameter int PIX_W = 8
) (
  input  logic                    clk,
  input  logic                    en,
  input  logic signed [RES_W-1:0] res_i,
  input  logic        [PIX_W-1:0] pred_i,
  output logic signed [RES_W-1:0] res_o,
  output logic        [PIX_W-1:0] pix_o
);
  localparam int SUM_W   = RES_W + 1;
  localparam int PIX_MAX = (1 << PIX_W) - 1;

  logic signed [SUM_W-1:0] sum_q;
  logic signed [RES_W-1:0] res_a;
  logic        [PIX_W-1:0] pix_d;

  always_comb begin
    if (sum_q < 0)                        pix_d = '0;
    else if (sum_q > SUM_W'(PIX_MAX))     pix_d = '1;
    else                                  pix_d = sum_q[PIX_W-1:0];
  end

  // first register: add; second register: clip
  always_ff @(posedge clk) begin
    if (en) begin
      sum_q <= SUM_W'(res_i) + SUM_W'({1'b0, pred_i});
      res_a <= res_i;
      res_o <= res_a;
      pix_o <= pix_d;
    end
  end
endmodule

// File: rtl/itx4_recon.sv
module itx4_recon
  import itx_pkg::*;
#(
  parameter int IN_W  = 16,
  parameter int PIX_W = 8
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            in_valid,
  output logic                            in_ready,
  input  logic [N_LANE*IN_W-1:0]          in_coef,
  input  logic [N_LANE*PIX_W-1:0]         in_pred,
  output logic                            out_valid,
  input  logic                            out_ready,
  output logic [N_LANE*(IN_W+GROWTH-RND_SH)-1:0] out_res,
  output logic [N_LANE*PIX_W-1:0]         out_pix
);
  localparam int ACC_W = IN_W + GROWTH;
  localparam int RES_W = ACC_W - RND_SH;
  localparam logic signed [ACC_W-1:0] RND_BIAS = ACC_W'(RND_OFS);

  logic adv;
  logic v_row, v_col, v_sum, v_out;

  logic signed [ACC_W-1:0] cin   [N_LANE];
  logic signed [ACC_W-1:0] row_d [N_LANE];
  logic signed [ACC_W-1:0] row_q [N_LANE];
  logic signed [ACC_W-1:0] col_d [N_LANE];
  logic signed [RES_W-1:0] res_q [N_LANE];
  logic        [PIX_W-1:0] pred_a[N_LANE];
  logic        [PIX_W-1:0] pred_b[N_LANE];

  // whole pipeline moves together
  assign adv       = !v_out || out_ready;
  assign in_ready  = adv;
  assign out_valid = v_out;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_row <= 1'b0;
      v_col <= 1'b0;
      v_sum <= 1'b0;
      v_out <= 1'b0;
    end else if (adv) begin
      v_row <= in_valid;
      v_col <= v_row;
      v_sum <= v_col;
      v_out <= v_sum;
    end
  end

  for (genvar k = 0; k < N_LANE; k++) begin : g_ext
    assign cin[k] = ACC_W'($signed(in_coef[k*IN_W +: IN_W]));
  end

  // first pass: one unit per row
  for (genvar r = 0; r < N_SIDE; r++) begin : g_row
    itx_bfly #(.W(ACC_W)) u_bf (
      .x0(cin[r*N_SIDE+0]),   .x1(cin[r*N_SIDE+1]),
      .x2(cin[r*N_SIDE+2]),   .x3(cin[r*N_SIDE+3]),
      .y0(row_d[r*N_SIDE+0]), .y1(row_d[r*N_SIDE+1]),
      .y2(row_d[r*N_SIDE+2]), .y3(row_d[r*N_SIDE+3])
    );
  end

  // second pass: one unit per column
  for (genvar c = 0; c < N_SIDE; c++) begin : g_col
    itx_bfly #(.W(ACC_W)) u_bf (
      .x0(row_q[0*N_SIDE+c]), .x1(row_q[1*N_SIDE+c]),
      .x2(row_q[2*N_SIDE+c]), .x3(row_q[3*N_SIDE+c]),
      .y0(col_d[0*N_SIDE+c]), .y1(col_d[1*N_SIDE+c]),
      .y2(col_d[2*N_SIDE+c]), .y3(col_d[3*N_SIDE+c])
    );
  end

  always_ff @(posedge clk) begin
    if (adv) begin
      for (int k = 0; k < N_LANE; k++) begin
        row_q[k]  <= row_d[k];
        pred_a[k] <= in_pred[k*PIX_W +: PIX_W];
        res_q[k]  <= RES_W'((col_d[k] + RND_BIAS) >>> RND_SH);
        pred_b[k] <= pred_a[k];
      end
    end
  end

  for (genvar k = 0; k < N_LANE; k++) begin : g_lane
    itx_recon_lane #(.RES_W(RES_W), .PIX_W(PIX_W)) u_lane (
      .clk   (clk),
      .en    (adv),
      .res_i (res_q[k]),
      .pred_i(pred_b[k]),
      .res_o (out_res[k*RES_W +: RES_W]),
      .pix_o (out_pix[k*PIX_W +: PIX_W])
    );
  end
endmodule

// File: rtl/itx4_recon_chk.sv
module itx4_recon_chk
  import itx_pkg::*;
#(
  parameter int IN_W  = 16,
  parameter int PIX_W = 8
) (
  input logic                                   clk,
  input logic                                   rst_n,
  input logic                                   in_ready,
  input logic                                   out_valid,
  input logic                                   out_ready,
  input logic [N_LANE*(IN_W+GROWTH-RND_SH)-1:0] out_res,
  input logic [N_LANE*PIX_W-1:0]                out_pix
);
  localparam int RES_W   = IN_W + GROWTH - RND_SH;
  localparam int PIX_MAX = (1 << PIX_W) - 1;

  // R8
  rst_idle_chk: assert property (@(posedge clk) !rst_n |=> !out_valid);

  // R1
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_res) && $stable(out_pix)));

  // R1
  stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  for (genvar k = 0; k < N_LANE; k++) begin : g_clip
    // R4
    clip_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && ($signed(out_res[k*RES_W +: RES_W]) >= PIX_MAX))
      |-> (out_pix[k*PIX_W +: PIX_W] == PIX_W'(PIX_MAX)));
    // R4
    clip_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && ($signed(out_res[k*RES_W +: RES_W]) <= -PIX_MAX))
      |-> (out_pix[k*PIX_W +: PIX_W] == '0));
  end
endmodule

bind itx4_recon itx4_recon_chk #(.IN_W(IN_W), .PIX_W(PIX_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_ready (in_ready),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_res  (out_res),
  .out_pix  (out_pix)
);

// File: tb/tb_itx4_recon.sv
module tb_itx4_recon;
  localparam int N     = 16;
  localparam int IN_W  = 16;
  localparam int PIX_W = 8;
  localparam int RES_W = 15;

  // dc coefficient, prediction, expected residual, expected pixel
  localparam int NTBL = 10;
  localparam int TBL [NTBL][4] = '{
    '{64, 100, 1, 101},   '{640, 3, 10, 13},     '{6400, 200, 100, 255},
    '{-640, 5, -10, 0},   '{-33, 0, -1, 0},      '{32, 254, 1, 255},
    '{31, 128, 0, 128},   '{0, 77, 0, 77},       '{-64, 1, -1, 0},
    '{-6400, 90, -100, 0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [N*IN_W-1:0]  in_coef = '0;
  logic [N*PIX_W-1:0] in_pred = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [N*RES_W-1:0] out_res;
  logic [N*PIX_W-1:0] out_pix;

  always #5 clk = ~clk;

  itx4_recon dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_coef(in_coef), .in_pred(in_pred), .out_valid(out_valid),
    .out_ready(out_ready), .out_res(out_res), .out_pix(out_pix)
  );

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  int acc_cyc = 0;
  bit bp = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  bit stall_prev = 1'b0;
  logic [N*RES_W-1:0] hold_res;
  logic [N*PIX_W-1:0] hold_pix;
  logic [N*RES_W-1:0] q_res[$];
  logic [N*PIX_W-1:0] q_pix[$];
  string q_tag[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [255:0] act, input logic [255:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // output side: consumer pattern, stall hold, result compare
  always @(negedge clk) begin
    if (rst_n) begin
      if (stall_prev)
        check(out_valid && out_res == hold_res && out_pix == hold_pix, "R1",
              "held output", {out_res, 8'(out_valid)}, {hold_res, 8'd1});
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      out_ready = bp ? lfsr[0] : 1'b1;
      stall_prev = out_valid && !out_ready;
      hold_res = out_res;
      hold_pix = out_pix;
      if (out_valid && out_ready) begin
        if (q_res.size() == 0) begin
          check(1'b0, "R6", "unexpected output", 256'(out_res), '0);
        end else begin
          logic [N*RES_W-1:0] er;
          logic [N*PIX_W-1:0] ep;
          string tg;
          er = q_res.pop_front();
          ep = q_pix.pop_front();
          tg = q_tag.pop_front();
          check(out_res == er, tg, "residual", 256'(out_res), 256'(er));
          check(out_pix == ep, tg, "pixel", 256'(out_pix), 256'(ep));
        end
      end
    end
  end

  task automatic bfly(input int a0, a1, a2, a3, output int y0, y1, y2, y3);
    int s, d, lo, hi;
    s = a0 + a2;  d = a0 - a2;
    lo = (a1 >>> 1) - a3;  hi = a1 + (a3 >>> 1);
    y0 = s + hi;  y1 = d + lo;  y2 = d - lo;  y3 = s - hi;
  endtask

  task automatic model(input int c[N], input int p[N],
                       output logic [N*RES_W-1:0] er, output logic [N*PIX_W-1:0] ep);
    int h[N];
    int f[N];
    for (int r = 0; r < 4; r++)
      bfly(c[4*r], c[4*r+1], c[4*r+2], c[4*r+3], h[4*r], h[4*r+1], h[4*r+2], h[4*r+3]);
    for (int q = 0; q < 4; q++)
      bfly(h[q], h[4+q], h[8+q], h[12+q], f[q], f[4+q], f[8+q], f[12+q]);
    for (int k = 0; k < N; k++) begin
      int rv, pv;
      rv = (f[k] + 32) >>> 6;
      pv = rv + p[k];
      if (pv < 0) pv = 0;
      if (pv > 255) pv = 255;
      er[k*RES_W +: RES_W] = RES_W'(rv);
      ep[k*PIX_W +: PIX_W] = PIX_W'(pv);
    end
  endtask

  task automatic send(input int c[N], input int p[N],
                      input logic [N*RES_W-1:0] er, input logic [N*PIX_W-1:0] ep,
                      input string tag);
    @(negedge clk);
    in_valid = 1'b1;
    for (int k = 0; k < N; k++) begin
      in_coef[k*IN_W +: IN_W] = IN_W'(c[k]);
      in_pred[k*PIX_W +: PIX_W] = PIX_W'(p[k]);
    end
    #1;
    while (!in_ready) begin
      if (out_valid && !out_ready)
        check(!in_ready, "R1", "ready while stalled", 256'(in_ready), '0);
      @(negedge clk);
      #1;
    end
    q_res.push_back(er);
    q_pix.push_back(ep);
    q_tag.push_back(tag);
    acc_cyc = cyc;
    @(posedge clk);
  endtask

  task automatic send_model(input int c[N], input int p[N], input string tag);
    logic [N*RES_W-1:0] er;
    logic [N*PIX_W-1:0] ep;
    model(c, p, er, ep);
    send(c, p, er, ep, tag);
  endtask

  task automatic go_idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic drain(input string tag);
    int t = 0;
    go_idle();
    while (q_res.size() != 0 && t < 2000) begin
      @(negedge clk);
      t++;
    end
    check(q_res.size() == 0, tag, "results outstanding", 256'(q_res.size()), '0);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL R6 watchdog: actual hang expected completion");
    finish_run();
  end

  initial begin
    int c[N];
    int p[N];
    logic [N*RES_W-1:0] er;
    logic [N*PIX_W-1:0] ep;

    // R8: reset state
    repeat (3) @(negedge clk);
    check(!out_valid && in_ready, "R8", "reset out_valid/in_ready",
          256'({out_valid, in_ready}), 256'(2'b01));
    rst_n = 1'b1;

    // R3 R4: table of dc-only blocks
    for (int i = 0; i < NTBL; i++) begin
      for (int k = 0; k < N; k++) begin
        c[k] = (k == 0) ? TBL[i][0] : 0;
        p[k] = TBL[i][1];
        er[k*RES_W +: RES_W] = RES_W'(TBL[i][2]);
        ep[k*PIX_W +: PIX_W] = PIX_W'(TBL[i][3]);
      end
      send(c, p, er, ep, "R3_R4");
    end
    drain("R3");

    // R5: latency from an empty pipeline
    begin
      int n = 0;
      for (int k = 0; k < N; k++) begin c[k] = 100 * k - 700; p[k] = 16 * k; end
      send_model(c, p, "R5");
      go_idle();
      n = 1;
      while (!out_valid && n < 20) begin @(negedge clk); n++; end
      check(n == 4, "R5", "latency", 256'(n), 256'(4));
      drain("R5");
    end

    // R2: varied patterns including odd values for the halving
    for (int i = 0; i < 8; i++) begin
      for (int k = 0; k < N; k++) begin
        c[k] = int'($urandom_range(0, 4095)) - 2048;
        p[k] = int'($urandom_range(0, 255));
      end
      send_model(c, p, "R2");
    end
    for (int k = 0; k < N; k++) begin c[k] = (k % 2 == 1) ? -63 : 5; p[k] = 128; end
    send_model(c, p, "R2");
    drain("R2");

    // R7: extreme inputs
    for (int k = 0; k < N; k++) begin c[k] = 32767; p[k] = 0; end
    send_model(c, p, "R7");
    for (int k = 0; k < N; k++) begin c[k] = -32768; p[k] = 255; end
    send_model(c, p, "R7");
    for (int k = 0; k < N; k++) begin
      c[k] = (((k / 4) + (k % 4)) % 2 == 0) ? 32767 : -32768;
      p[k] = 60;
    end
    send_model(c, p, "R7");
    for (int k = 0; k < N; k++) begin c[k] = (k % 4 == 1 || k % 4 == 3) ? -32768 : 32767; p[k] = 9; end
    send_model(c, p, "R7");
    drain("R7");

    // R6: sustained one block per cycle
    begin
      int first = 0;
      for (int i = 0; i < 8; i++) begin
        for (int k = 0; k < N; k++) begin c[k] = 37 * i - 9 * k; p[k] = 20 * i + k; end
        send_model(c, p, "R6");
        if (i == 0) first = acc_cyc;
      end
      check(acc_cyc - first == 7, "R6", "cycles for 8 blocks", 256'(acc_cyc - first), 256'(7));
      drain("R6");
    end

    // R1: random back-pressure while streaming
    bp = 1'b1;
    for (int i = 0; i < 24; i++) begin
      for (int k = 0; k < N; k++) begin
        c[k] = int'($urandom_range(0, 65535)) - 32768;
        p[k] = int'($urandom_range(0, 255));
      end
      send_model(c, p, "R1");
    end
    drain("R1");
    bp = 1'b0;

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule